// File: doc/BRIEF.md
# Fifth-Order Lowpass Lattice Wave Digital Filter

This block is a fixed-coefficient lowpass filter of odd order five. It splits the incoming sample stream into two allpass branches. One branch is a first-order allpass section followed by a second-order allpass section. The other branch is a single second-order allpass section. The two branch outputs are added, and the sum is halved to give the filter output. The allpass responses differ in order by one, so their average passes low frequencies and cancels high ones.

All coefficient products are fixed shift-and-add networks. The shift positions come from a canonic-signed-digit recoding of each integer coefficient, which is computed when the design is elaborated. No general multiplier appears anywhere. Each sample runs through the allpass sections in one cycle. The halved sum is registered and presented one clock after the input strobe. Between strobes the filter state and the output are frozen.

Top module: `lattice_wdf_lp`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every delay register is cleared to zero. After that edge `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high. It is low in the cycle after an edge at which `in_valid` was low.
- R3: An edge with `in_valid` low leaves every section state unchanged and leaves `out_data` unchanged. The next valid sample continues exactly as though the idle cycles had not happened.
- R4: The first-order section computes y[n] = floor(T0·(x[n] − y[n−1]) / 2^FRAC) + x[n−1]. The default T0 is −649, which is −0.6338 in units of 2^−10.
- R5: A second-order section computes y[n] = floor(C2·(x[n] − y[n−2]) / 2^FRAC) + floor(C1·(x[n−1] − y[n−1]) / 2^FRAC) + x[n−2].
- R6: Branch 0 is the first-order section followed by a second-order section with C1 = −702 and C2 = 846. Branch 1 is a second-order section with C1 = −1040 and C2 = 550. Both branches take the same sign-extended input.
- R7: The output is floor((branch0 + branch1) / 2). The halving is an arithmetic right shift by one that truncates.
- R8: Internal words are IN_W + GUARD = 12 bits in two's complement. Each section output wraps to 12 bits, with no saturation. Full-scale inputs of −128 and +127 are handled without any other loss.
- R9: A constant input of 100 settles to an output within ±4 LSB of 100, which is unity DC gain.
- R10: The impulse response, and the response to an arbitrary valid/idle sample sequence, match the integer equations of R4 to R7 bit for bit on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` and advances the filter by one sample |
| in_data | input | IN_W (8) | Signed input sample |
| out_valid | output | 1 | High for one cycle when `out_data` holds a new sample |
| out_data | output | IN_W+GUARD (12) | Signed filter output, held between samples |

## Verification
The assertions check these on every cycle:
- the reset clearing of the output and of every section state;
- the one-clock valid latency;
- the freezing of state and output on idle cycles.

They cannot judge the arithmetic. The bench's integer model confirms the exact numerical behaviour, clock by clock, across an impulse, full-scale impulses of both signs, a pseudo-random sequence with idle gaps, and a long constant input. That covers:
- the section equations and their floor rounding;
- the branch wiring;
- the truncating halving;
- the DC settling value.

// File: rtl/lwdf_pkg.sv
// Package: shared constants and the canonic-signed-digit recoder used by
// every constant multiplier. Assumes coefficients fit in CSD_DIGITS digits.
package lwdf_pkg;

    localparam int CSD_DIGITS = 16;

    // Returns a mask of the +1 digits (want_neg = 0) or the -1 digits
    // (want_neg = 1) of the canonic signed-digit form of value.
    function automatic logic [CSD_DIGITS-1:0] csd_mask(input int value, input bit want_neg);
        int v;
        int d;
        logic [CSD_DIGITS-1:0] m;
        v = value;
        m = '0;
        for (int i = 0; i < CSD_DIGITS; i++) begin
            d = 0;
            if (v[0]) d = v[1] ? -1 : 1;
            if ((d > 0 && !want_neg) || (d < 0 && want_neg)) m[i] = 1'b1;
            v = (v - d) >>> 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lwdf_csd_mul.sv
// Constant multiplier: dout = floor(din * COEF / 2^FRAC), built only from
// shifted adds and subtracts of din.
// Assumes |COEF| < 2^(FRAC+1), so the result fits IN_W+1 bits.
module lwdf_csd_mul #(
    parameter int IN_W = 13,
    parameter int FRAC = 10,
    parameter int COEF = 0
) (
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W:0]   dout
);
    localparam int ACC_W = IN_W + lwdf_pkg::CSD_DIGITS + 1;
    localparam logic [lwdf_pkg::CSD_DIGITS-1:0] POS = lwdf_pkg::csd_mask(COEF, 1'b0);
    localparam logic [lwdf_pkg::CSD_DIGITS-1:0] NEG = lwdf_pkg::csd_mask(COEF, 1'b1);

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] acc;
    logic                    unused_bits;

    // Sum the signed-digit partial products of the sign-extended input.
    always_comb begin
        ext = {{(ACC_W-IN_W){din[IN_W-1]}}, din};
        acc = '0;
        for (int i = 0; i < lwdf_pkg::CSD_DIGITS; i++) begin
            if (POS[i]) acc = acc + (ext <<< i);
            if (NEG[i]) acc = acc - (ext <<< i);
        end
    end

    // Drop FRAC fraction bits: the bit slice is a floor division.
    assign dout        = acc[FRAC +: IN_W+1];
    assign unused_bits = ^{acc[FRAC-1:0], acc[ACC_W-1:FRAC+IN_W+1]};

endmodule

// File: rtl/lwdf_ap1.sv
// First-order allpass section (t + z^-1)/(1 + t z^-1) in one-multiplier form:
// y = floor(T*(x - y1)/2^FRAC) + x1. The output is combinational from x.
// The state advances only when en is high. The output wraps to W bits.
module lwdf_ap1 #(
    parameter int W    = 12,
    parameter int FRAC = 10,
    parameter int T    = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] x_d, y_d;
    logic signed [W:0]   diff;
    logic signed [W+1:0] prod;
    logic signed [W+2:0] sum;
    logic                unused_top;

    assign diff = {x[W-1], x} - {y_d[W-1], y_d};

    lwdf_csd_mul #(.IN_W(W+1), .FRAC(FRAC), .COEF(T)) u_mul (.din(diff), .dout(prod));

    assign sum        = {prod[W+1], prod} + {{3{x_d[W-1]}}, x_d};
    assign y          = sum[W-1:0];
    assign unused_top = ^sum[W+2:W];

    // Hold the previous input and output sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_d <= '0;
            y_d <= '0;
        end else if (en) begin
            x_d <= x;
            y_d <= y;
        end
    end

    AST_AP1_CLEARED: assert property (@(posedge clk) !rst_n |=> (x_d == '0 && y_d == '0)); // R1
    AST_AP1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !en |=> ($stable(x_d) && $stable(y_d))); // R3

endmodule

// File: rtl/lwdf_ap2.sv
// Second-order allpass section (t2 + t1 z^-1 + z^-2)/(1 + t1 z^-1 + t2 z^-2):
// y = floor(C2*(x - y2)/2^FRAC) + floor(C1*(x1 - y1)/2^FRAC) + x2.
// The output is combinational. The state advances on en. The output wraps to W bits.
module lwdf_ap2 #(
    parameter int W    = 12,
    parameter int FRAC = 10,
    parameter int C1   = 0,
    parameter int C2   = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] x1, x2, y1, y2;
    logic signed [W:0]   d_now, d_old;
    logic signed [W+1:0] p_now, p_old;
    logic signed [W+3:0] sum;
    logic                unused_top;

    assign d_now = {x[W-1], x} - {y2[W-1], y2};
    assign d_old = {x1[W-1], x1} - {y1[W-1], y1};

    lwdf_csd_mul #(.IN_W(W+1), .FRAC(FRAC), .COEF(C2)) u_mul2 (.din(d_now), .dout(p_now));
    lwdf_csd_mul #(.IN_W(W+1), .FRAC(FRAC), .COEF(C1)) u_mul1 (.din(d_old), .dout(p_old));

    assign sum        = {{2{p_now[W+1]}}, p_now} + {{2{p_old[W+1]}}, p_old} + {{4{x2[W-1]}}, x2};
    assign y          = sum[W-1:0];
    assign unused_top = ^sum[W+3:W];

    // Shift the two-deep input and output delay lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x1 <= '0; x2 <= '0; y1 <= '0; y2 <= '0;
        end else if (en) begin
            x1 <= x;  x2 <= x1;
            y1 <= y;  y2 <= y1;
        end
    end

    AST_AP2_CLEARED: assert property (@(posedge clk) !rst_n |=> (x1 == '0 && x2 == '0 && y1 == '0 && y2 == '0)); // R1
    AST_AP2_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !en |=> ($stable(y1) && $stable(y2) && $stable(x1) && $stable(x2))); // R3

endmodule

// File: rtl/lattice_wdf_lp.sv
// Fifth-order lowpass lattice wave digital filter. Branch 0 is a first-order
// allpass followed by a second-order allpass. Branch 1 is a second-order
// allpass. The output is the truncated half of the branch sum, registered,
// so it appears one clock after in_valid. Coefficients are integers scaled
// by 2^FRAC. Internal words are IN_W+GUARD bits and wrap on overflow.
module lattice_wdf_lp #(
    parameter int IN_W  = 8,
    parameter int GUARD = 4,
    parameter int FRAC  = 10,
    parameter int T0    = -649,
    parameter int A1    = -702,
    parameter int A2    = 846,
    parameter int B1    = -1040,
    parameter int B2    = 550
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic signed [IN_W-1:0]        in_data,
    output logic                          out_valid,
    output logic signed [IN_W+GUARD-1:0]  out_data
);
    localparam int W = IN_W + GUARD;

    logic signed [W-1:0] x_ext, br0_mid, br0, br1;
    logic signed [W:0]   br_sum;
    logic                unused_lsb;

    assign x_ext = {{GUARD{in_data[IN_W-1]}}, in_data};

    lwdf_ap1 #(.W(W), .FRAC(FRAC), .T(T0)) u_br0_s1 (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .x(x_ext), .y(br0_mid));
    lwdf_ap2 #(.W(W), .FRAC(FRAC), .C1(A1), .C2(A2)) u_br0_s2 (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .x(br0_mid), .y(br0));
    lwdf_ap2 #(.W(W), .FRAC(FRAC), .C1(B1), .C2(B2)) u_br1_s1 (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .x(x_ext), .y(br1));

    assign br_sum     = {br0[W-1], br0} + {br1[W-1], br1};
    assign unused_lsb = br_sum[0];

    // Register the halved branch sum and the matching valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= br_sum[W:1];
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_data == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R3

endmodule

// File: tb/lattice_wdf_lp_test.sv
module lattice_wdf_lp_test;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [7:0] in_data;
    logic out_valid;
    logic signed [W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1 reset";

    // Behavioural model state
    longint s1x, s1y;
    longint s2x1, s2x2, s2y1, s2y2;
    longint s3x1, s3x2, s3y1, s3y2;
    bit     exp_v;
    longint exp_d;

    always #2 clk = ~clk;

    lattice_wdf_lp uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data));

    function automatic longint wr(input longint v);
        logic signed [W-1:0] t;
        t = v[W-1:0];
        return longint'(t);
    endfunction

    function automatic longint fl(input longint c, input longint d);
        return (c * d) >>> 10;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: advances on each valid sample at the clock edge.
    always @(posedge clk) begin
        longint x, a, b0, b1;
        if (!rst_n) begin
            s1x = 0; s1y = 0;
            s2x1 = 0; s2x2 = 0; s2y1 = 0; s2y2 = 0;
            s3x1 = 0; s3x2 = 0; s3y1 = 0; s3y2 = 0;
            exp_v = 0; exp_d = 0;
        end else begin
            exp_v = in_valid;
            if (in_valid) begin
                x  = longint'(in_data);
                a  = wr(fl(-649, x - s1y) + s1x);                   // R4
                s1x = x; s1y = a;
                b0 = wr(fl(846, a - s2y2) + fl(-702, s2x1 - s2y1) + s2x2); // R5 R6
                s2x2 = s2x1; s2x1 = a; s2y2 = s2y1; s2y1 = b0;
                b1 = wr(fl(550, x - s3y2) + fl(-1040, s3x1 - s3y1) + s3x2); // R6
                s3x2 = s3x1; s3x1 = x; s3y2 = s3y1; s3y1 = b1;
                exp_d = (b0 + b1) >>> 1;                           // R7
            end
        end
    end

    // Compare outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n !== 1'bx) begin
            check(out_valid == exp_v, {phase, " valid R2"}, longint'(out_valid), longint'(exp_v));
            check(out_data == exp_d, {phase, " data R10"}, longint'(out_data), exp_d);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic drive(input bit v, input int d);
        @(negedge clk);
        in_valid = v;
        in_data  = 8'(d);
    endtask

    initial begin
        int seed;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
        check(out_data == '0, "R1 reset out_data", longint'(out_data), 0);
        rst_n = 1'b1;

        phase = "R4 R5 R6 R7 impulse";
        drive(1, 100);
        for (int i = 0; i < 40; i++) drive(1, 0);

        phase = "R3 gaps";
        for (int i = 0; i < 30; i++) begin
            drive(1, (i % 3 == 0) ? 60 : -35);
            drive(0, 99);
            drive(0, -99);
        end
        drive(0, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 idle out_valid", longint'(out_valid), 0);

        phase = "R8 fullscale";
        drive(1, -128);
        for (int i = 0; i < 30; i++) drive(1, 0);
        drive(1, 127);
        for (int i = 0; i < 30; i++) drive(1, 0);
        for (int i = 0; i < 20; i++) drive(1, (i % 2) ? 127 : -128);

        phase = "R10 random";
        seed = 12345;
        for (int i = 0; i < 300; i++) begin
            seed = seed * 1103515245 + 12345;
            drive(seed[20], int'($signed(seed[23:16])));
        end

        phase = "R1 midreset";
        drive(1, 50);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 midrun reset", longint'(out_data), 0);
        rst_n = 1'b1;

        phase = "R9 dc";
        for (int i = 0; i < 400; i++) drive(1, 100);
        drive(0, 0);
        @(negedge clk);
        check(out_data >= 96 && out_data <= 104, "R9 dc gain", longint'(out_data), 100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule